// File: doc/BRIEF.md
# Paged Program Counter Next-Address Unit

This block works out where a small 8-bit controller goes next. The controller has a 15-bit program counter and several kinds of control transfer, and each kind keeps a different part of the current address. A full-range jump replaces the whole address. A page jump replaces the low twelve bits and keeps the top three. A one-byte relative jump moves up to 31 bytes forward or 32 bytes backward with a full 15-bit add. A table jump replaces the low byte with a byte read from ROM. A software trap goes to a fixed vector, and returns use an address popped from the stack. For every other instruction the address moves forward by the instruction length.

The fetch logic presents one instruction per `step_i` pulse, along with its decoded transfer kind, its bytes, the accumulator, the ROM table byte and the popped return address. One clock later the unit shows the registered next address. It also keeps the skip state. A compare that fails, or a return-and-skip, marks the next instruction as suppressed. A suppressed instruction only advances the address by its own length. A direct-address prefix that is suppressed passes the skip on, so that the prefix and the instruction it modifies are dropped as a pair.

Top module: `paged_pc_unit`

## Requirements
- R1: While reset is held, and in the cycle after it, `pc_next_o` is 0 and `skip_pend_o` is 0.
- R2: Sequential instructions (`xfer_i` = 0) produce `pc_i + len_i` one cycle after the step. `len_i` holds the byte count 1, 2 or 3, and the sum wraps at 15 bits.
- R3: A full-range jump (`xfer_i` = 1) produces `{opnd_a_i[6:0], opnd_b_i}`.
- R4: A page jump (`xfer_i` = 2) keeps `pc_i[14:12]` and sets the low twelve bits to `{opcode_i[3:0], opnd_a_i}`.
- R5: A relative transfer (`xfer_i` = 3) whose `opcode_i[7:5]` is 000 and whose offset `opcode_i[4:0]` is not zero produces `pc_i + offset`. With an offset of zero it behaves as a sequential instruction.
- R6: A relative transfer with `opcode_i[7:5]` = 111 produces `pc_i - 32 + opcode_i[4:0]`, wrapping at 15 bits.
- R7: `tbl_addr_o` always equals `{pc_i[14:8], acc_i}`. A table jump (`xfer_i` = 4) produces `{pc_i[14:8], rom_byte_i}`.
- R8: A software trap (`xfer_i` = 5) produces 15'h00FF.
- R9: A return (`xfer_i` = 6) produces `ret_pc_i` and leaves the skip flag clear. A return-and-skip (`xfer_i` = 7) produces `ret_pc_i` and sets `skip_pend_o`.
- R10: A step with `skip_req_i` high sets `skip_pend_o`. The next non-prefix step is suppressed: it produces `pc_i + len_i` whatever its `xfer_i`, its `skip_req_i` has no effect, and it clears `skip_pend_o`.
- R11: A suppressed step with `prefix_i` high advances by its length and keeps `skip_pend_o` set, so the step after it is suppressed too.
- R12: With `step_i` low, `pc_next_o` and `skip_pend_o` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step_i | input | 1 | An instruction is presented this cycle |
| xfer_i | input | 3 | Decoded transfer kind (codes as in R2 to R9) |
| len_i | input | 2 | Instruction length in bytes, 1 to 3 |
| pc_i | input | 15 | Address of the presented instruction |
| opcode_i | input | 8 | First instruction byte |
| opnd_a_i | input | 8 | Second instruction byte |
| opnd_b_i | input | 8 | Third instruction byte |
| acc_i | input | 8 | Accumulator, used to index the ROM table |
| rom_byte_i | input | 8 | ROM byte read at `tbl_addr_o` |
| ret_pc_i | input | 15 | Address popped from the stack |
| skip_req_i | input | 1 | The presented instruction asks to skip the next one |
| prefix_i | input | 1 | The presented instruction is a direct-address prefix |
| tbl_addr_o | output | 15 | ROM table address for table jumps |
| pc_next_o | output | 15 | Registered next program counter |
| skip_pend_o | output | 1 | The next presented instruction will be suppressed |

## Verification
The hardest case to reach from the ports is a suppressed prefix. It needs three steps in a fixed order: one step that raises the skip, then a prefix that arrives while the skip is pending, then an instruction that must also be dropped even though it is a page jump. The stimulus builds this chain on purpose and follows it with a normal page jump, to show the skip does not last too long. A similar chain starts from return-and-skip with a full-range jump as the victim. Another suppressed step asks for a skip of its own, which must be ignored. The wrap cases of the relative add, both forward past the top of memory and backward below zero, are driven with chosen addresses.

// File: rtl/paged_pc_pkg.sv
package paged_pc_pkg;

    typedef enum logic [2:0] {
        XF_SEQ    = 3'd0,
        XF_LONG   = 3'd1,
        XF_PAGE   = 3'd2,
        XF_REL    = 3'd3,
        XF_TABLE  = 3'd4,
        XF_TRAP   = 3'd5,
        XF_RET    = 3'd6,
        XF_RETSK  = 3'd7
    } xfer_e;

    localparam int unsigned DEF_PC_W   = 15;
    localparam int unsigned DEF_PAGE_W = 12;
    localparam int unsigned DEF_TBL_W  = 8;
    localparam int unsigned DEF_REL_W  = 5;
    localparam int unsigned BYTE_W     = 8;

endpackage

// File: rtl/paged_pc_target.sv
module paged_pc_target
    import paged_pc_pkg::*;
#(
    parameter int unsigned PC_W    = DEF_PC_W,
    parameter int unsigned PAGE_W  = DEF_PAGE_W,
    parameter int unsigned TBL_W   = DEF_TBL_W,
    parameter int unsigned REL_W   = DEF_REL_W,
    parameter logic [PC_W-1:0] TRAP_VEC = PC_W'(16'h00FF)
) (
    input  xfer_e             xfer,
    input  logic [1:0]        len,
    input  logic [PC_W-1:0]   pc,
    input  logic [BYTE_W-1:0] opcode,
    input  logic [BYTE_W-1:0] opnd_a,
    input  logic [BYTE_W-1:0] opnd_b,
    input  logic [BYTE_W-1:0] acc,
    input  logic [BYTE_W-1:0] rom_byte,
    input  logic [PC_W-1:0]   ret_pc,
    output logic [PC_W-1:0]   seq_pc,
    output logic [PC_W-1:0]   jump_pc,
    output logic [PC_W-1:0]   tbl_addr
);
    localparam int unsigned DIR_W  = BYTE_W - REL_W;
    localparam logic [PC_W-1:0] BACK_SPAN = PC_W'(1 << REL_W);

    logic [REL_W-1:0] rel_off;
    logic [DIR_W-1:0] rel_dir;
    logic [PC_W-1:0]  long_tgt;
    logic [PC_W-1:0]  page_tgt;
    logic [PC_W-1:0]  fwd_tgt;
    logic [PC_W-1:0]  bwd_tgt;
    logic [PC_W-1:0]  tbl_tgt;

    assign rel_off  = opcode[REL_W-1:0];
    assign rel_dir  = opcode[BYTE_W-1:REL_W];

    assign seq_pc   = pc + PC_W'(len);
    assign long_tgt = PC_W'({opnd_a, opnd_b});
    assign page_tgt = {pc[PC_W-1:PAGE_W], PAGE_W'({opcode, opnd_a})};
    assign fwd_tgt  = pc + PC_W'(rel_off);
    assign bwd_tgt  = pc - BACK_SPAN + PC_W'(rel_off);
    assign tbl_addr = {pc[PC_W-1:TBL_W], acc[TBL_W-1:0]};
    assign tbl_tgt  = {pc[PC_W-1:TBL_W], rom_byte[TBL_W-1:0]};

    always_comb begin
        jump_pc = seq_pc;
        unique case (xfer)
            XF_SEQ:   jump_pc = seq_pc;
            XF_LONG:  jump_pc = long_tgt;
            XF_PAGE:  jump_pc = page_tgt;
            XF_REL: begin
                if (rel_dir == '0 && rel_off != '0) begin
                    jump_pc = fwd_tgt;
                end else if (rel_dir == '1) begin
                    jump_pc = bwd_tgt;
                end else begin
                    jump_pc = seq_pc;
                end
            end
            XF_TABLE: jump_pc = tbl_tgt;
            XF_TRAP:  jump_pc = TRAP_VEC;
            XF_RET:   jump_pc = ret_pc;
            XF_RETSK: jump_pc = ret_pc;
            default:  jump_pc = seq_pc;
        endcase
    end

endmodule

// File: rtl/paged_pc_skip.sv
module paged_pc_skip
    import paged_pc_pkg::*;
(
    input  logic  step,
    input  logic  pending,
    input  logic  prefix,
    input  logic  skip_req,
    input  xfer_e xfer,
    output logic  suppress,
    output logic  pending_nx
);
    always_comb begin
        suppress   = step && pending;
        pending_nx = pending;
        if (step) begin
            if (pending) begin
                // a suppressed prefix hands the skip to the instruction it modifies
                pending_nx = prefix;
            end else begin
                pending_nx = skip_req || (xfer == XF_RETSK);
            end
        end
    end

endmodule

// File: rtl/paged_pc_unit.sv
module paged_pc_unit
    import paged_pc_pkg::*;
#(
    parameter int unsigned PC_W   = DEF_PC_W,
    parameter int unsigned PAGE_W = DEF_PAGE_W,
    parameter int unsigned TBL_W  = DEF_TBL_W,
    parameter int unsigned REL_W  = DEF_REL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_i,
    input  logic [2:0]        xfer_i,
    input  logic [1:0]        len_i,
    input  logic [PC_W-1:0]   pc_i,
    input  logic [7:0]        opcode_i,
    input  logic [7:0]        opnd_a_i,
    input  logic [7:0]        opnd_b_i,
    input  logic [7:0]        acc_i,
    input  logic [7:0]        rom_byte_i,
    input  logic [PC_W-1:0]   ret_pc_i,
    input  logic              skip_req_i,
    input  logic              prefix_i,
    output logic [PC_W-1:0]   tbl_addr_o,
    output logic [PC_W-1:0]   pc_next_o,
    output logic              skip_pend_o
);
    typedef struct packed {
        logic [PC_W-1:0] pc;
        logic            skip;
    } unit_state_t;

    unit_state_t st_d, st_q;
    xfer_e           xfer;
    logic [PC_W-1:0] seq_pc;
    logic [PC_W-1:0] jump_pc;
    logic            suppress;
    logic            skip_nx;

    assign xfer = xfer_e'(xfer_i);

    paged_pc_target #(
        .PC_W   (PC_W),
        .PAGE_W (PAGE_W),
        .TBL_W  (TBL_W),
        .REL_W  (REL_W)
    ) u_target (
        .xfer     (xfer),
        .len      (len_i),
        .pc       (pc_i),
        .opcode   (opcode_i),
        .opnd_a   (opnd_a_i),
        .opnd_b   (opnd_b_i),
        .acc      (acc_i),
        .rom_byte (rom_byte_i),
        .ret_pc   (ret_pc_i),
        .seq_pc   (seq_pc),
        .jump_pc  (jump_pc),
        .tbl_addr (tbl_addr_o)
    );

    paged_pc_skip u_skip (
        .step       (step_i),
        .pending    (st_q.skip),
        .prefix     (prefix_i),
        .skip_req   (skip_req_i),
        .xfer       (xfer),
        .suppress   (suppress),
        .pending_nx (skip_nx)
    );

    always_comb begin
        st_d      = st_q;
        st_d.skip = skip_nx;
        if (step_i) begin
            st_d.pc = suppress ? seq_pc : jump_pc;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pc_next_o   = st_q.pc;
    assign skip_pend_o = st_q.skip;

endmodule

// File: rtl/paged_pc_unit_chk.sv
module paged_pc_unit_chk
    import paged_pc_pkg::*;
#(
    parameter int unsigned PC_W = DEF_PC_W
) (
    input logic            clk,
    input logic            rst_n,
    input logic            step_i,
    input logic [2:0]      xfer_i,
    input logic [1:0]      len_i,
    input logic [PC_W-1:0] pc_i,
    input logic [7:0]      opnd_a_i,
    input logic [7:0]      opnd_b_i,
    input logic [PC_W-1:0] ret_pc_i,
    input logic            prefix_i,
    input logic [PC_W-1:0] pc_next_o,
    input logic            skip_pend_o
);
    logic [PC_W-1:0] chk_seq;
    logic [PC_W-1:0] chk_long;
    logic            live;

    assign chk_seq  = pc_i + PC_W'(len_i);
    assign chk_long = PC_W'({opnd_a_i, opnd_b_i});
    assign live     = step_i && !skip_pend_o;

    // R12: no step, no change
    a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !step_i |=> ($stable(pc_next_o) && $stable(skip_pend_o)));

    // R3: full-range jump target
    a_r3_long_target: assert property (@(posedge clk) disable iff (!rst_n)
        (live && xfer_i == 3'(XF_LONG)) |=> (pc_next_o == $past(chk_long)));

    // R8: trap vector
    a_r8_trap_vector: assert property (@(posedge clk) disable iff (!rst_n)
        (live && xfer_i == 3'(XF_TRAP)) |=> (pc_next_o == PC_W'(16'h00FF)));

    // R9: return-and-skip arms the skip
    a_r9_retsk_arms: assert property (@(posedge clk) disable iff (!rst_n)
        (live && xfer_i == 3'(XF_RETSK)) |=> (skip_pend_o && pc_next_o == $past(ret_pc_i)));

    // R10: suppressed step only advances and clears the skip
    a_r10_suppress: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && skip_pend_o && !prefix_i) |=> (!skip_pend_o && pc_next_o == $past(chk_seq)));

    // R11: suppressed prefix keeps the skip alive
    a_r11_prefix_pair: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && skip_pend_o && prefix_i) |=> skip_pend_o);

endmodule

bind paged_pc_unit paged_pc_unit_chk #(.PC_W(PC_W)) u_chk (.*);

// File: tb/paged_pc_unit_test.sv
`timescale 1ns/1ps
module paged_pc_unit_test;
    import paged_pc_pkg::*;

    typedef struct {
        logic [14:0] pc;
        logic        skip;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        step_i = 1'b0;
    logic [2:0]  xfer_i = '0;
    logic [1:0]  len_i = 2'd1;
    logic [14:0] pc_i = '0;
    logic [7:0]  opcode_i = '0;
    logic [7:0]  opnd_a_i = '0;
    logic [7:0]  opnd_b_i = '0;
    logic [7:0]  acc_i = '0;
    logic [7:0]  rom_byte_i = '0;
    logic [14:0] ret_pc_i = '0;
    logic        skip_req_i = 1'b0;
    logic        prefix_i = 1'b0;
    logic [14:0] tbl_addr_o;
    logic [14:0] pc_next_o;
    logic        skip_pend_o;

    int   n_checks = 0;
    int   n_fails  = 0;
    int   cycles   = 0;
    bit   done     = 1'b0;
    logic cmp_due  = 1'b0;
    exp_t sb[$];

    always #2 clk = ~clk;

    paged_pc_unit uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .step_i     (step_i),
        .xfer_i     (xfer_i),
        .len_i      (len_i),
        .pc_i       (pc_i),
        .opcode_i   (opcode_i),
        .opnd_a_i   (opnd_a_i),
        .opnd_b_i   (opnd_b_i),
        .acc_i      (acc_i),
        .rom_byte_i (rom_byte_i),
        .ret_pc_i   (ret_pc_i),
        .skip_req_i (skip_req_i),
        .prefix_i   (prefix_i),
        .tbl_addr_o (tbl_addr_o),
        .pc_next_o  (pc_next_o),
        .skip_pend_o(skip_pend_o)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // driver: present one instruction, queue its expected result
    task automatic issue(input xfer_e xf, input logic [1:0] ln, input logic [14:0] pc,
                         input logic [7:0] opc, input logic [7:0] a, input logic [7:0] b,
                         input logic [7:0] rom, input logic [14:0] ret,
                         input logic skreq, input logic pref,
                         input logic [14:0] exp_pc, input logic exp_skip, input string tag);
        exp_t e;
        @(negedge clk);
        step_i = 1'b1; xfer_i = xf; len_i = ln; pc_i = pc;
        opcode_i = opc; opnd_a_i = a; opnd_b_i = b; rom_byte_i = rom;
        ret_pc_i = ret; skip_req_i = skreq; prefix_i = pref;
        e.pc = exp_pc; e.skip = exp_skip; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            step_i = 1'b0; skip_req_i = 1'b0; prefix_i = 1'b0;
        end
    endtask

    // monitor: compare after the edge that registered each step
    always @(posedge clk) cmp_due <= rst_n && step_i;

    always @(negedge clk) begin
        if (cmp_due) begin
            if (sb.size() == 0) begin
                check("scoreboard underflow", 16'h1, 16'h0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check({e.tag, " pc"}, {1'b0, pc_next_o}, {1'b0, e.pc});
                check({e.tag, " skip"}, {15'b0, skip_pend_o}, {15'b0, e.skip});
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000 && !done) begin
            done = 1'b1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual %0d cycles expected below 5000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset pc", {1'b0, pc_next_o}, 16'h0);
        check("R1 reset skip", {15'b0, skip_pend_o}, 16'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset pc", {1'b0, pc_next_o}, 16'h0);

        // R2 sequential
        issue(XF_SEQ, 2'd1, 15'h0100, 8'h00, 8'h00, 8'h00, 8'h00, 15'h0, 0, 0, 15'h0101, 0, "R2 len1");
        issue(XF_SEQ, 2'd3, 15'h7FFE, 8'h00, 8'h00, 8'h00, 8'h00, 15'h0, 0, 0, 15'h0001, 0, "R2 wrap");
        issue(XF_SEQ, 2'd2, 15'h1234, 8'h00, 8'h00, 8'h00, 8'h00, 15'h0, 0, 0, 15'h1236, 0, "R2 len2");
        // R3 full-range
        issue(XF_LONG, 2'd3, 15'h0010, 8'hAC, 8'hD2, 8'h34, 8'h00, 15'h0, 0, 0, 15'h5234, 0, "R3 long");
        // R4 page jump
        issue(XF_PAGE, 2'd2, 15'h6ABC, 8'h2F, 8'h11, 8'h00, 8'h00, 15'h0, 0, 0, 15'h6F11, 0, "R4 page");
        // R5 forward relative
        issue(XF_REL, 2'd1, 15'h10F0, 8'h05, 8'h00, 8'h00, 8'h00, 15'h0, 0, 0, 15'h10F5, 0, "R5 fwd");
        issue(XF_REL, 2'd1, 15'h7FF0, 8'h1F, 8'h00, 8'h00, 8'h00, 15'h0, 0, 0, 15'h000F, 0, "R5 fwd wrap");
        issue(XF_REL, 2'd1, 15'h0200, 8'h00, 8'h00, 8'h00, 8'h00, 15'h0, 0, 0, 15'h0201, 0, "R5 zero offset");
        // R6 backward relative
        issue(XF_REL, 2'd1, 15'h0500, 8'hE0, 8'h00, 8'h00, 8'h00, 15'h0, 0, 0, 15'h04E0, 0, "R6 bwd 32");
        issue(XF_REL, 2'd1, 15'h0500, 8'hFF, 8'h00, 8'h00, 8'h00, 15'h0, 0, 0, 15'h04FF, 0, "R6 bwd 1");
        issue(XF_REL, 2'd1, 15'h0010, 8'hE4, 8'h00, 8'h00, 8'h00, 15'h0, 0, 0, 15'h7FF4, 0, "R6 bwd wrap");
        // R7 table jump
        acc_i = 8'h9C;
        issue(XF_TABLE, 2'd1, 15'h3A77, 8'h00, 8'h00, 8'h00, 8'h42, 15'h0, 0, 0, 15'h3A42, 0, "R7 table");
        #1 check("R7 table address", {1'b0, tbl_addr_o}, 16'h3A9C);
        // R8 trap
        issue(XF_TRAP, 2'd1, 15'h1234, 8'h00, 8'h00, 8'h00, 8'h00, 15'h0, 0, 0, 15'h00FF, 0, "R8 trap");
        // R9 returns, then R10 suppressed full-range jump
        issue(XF_RET, 2'd1, 15'h00FF, 8'h00, 8'h00, 8'h00, 8'h00, 15'h2468, 0, 0, 15'h2468, 0, "R9 ret");
        issue(XF_RETSK, 2'd1, 15'h2468, 8'h00, 8'h00, 8'h00, 8'h00, 15'h1357, 0, 0, 15'h1357, 1, "R9 retsk");
        issue(XF_LONG, 2'd3, 15'h1357, 8'hAC, 8'h7F, 8'hFF, 8'h00, 15'h0, 0, 0, 15'h135A, 0, "R10 after retsk");
        // R10 skip request, suppressed trap with its own skip request ignored
        issue(XF_SEQ, 2'd2, 15'h0040, 8'h00, 8'h00, 8'h00, 8'h00, 15'h0, 1, 0, 15'h0042, 1, "R10 arm");
        issue(XF_TRAP, 2'd1, 15'h0042, 8'h00, 8'h00, 8'h00, 8'h00, 15'h0, 1, 0, 15'h0043, 0, "R10 suppressed");
        issue(XF_SEQ, 2'd1, 15'h0043, 8'h00, 8'h00, 8'h00, 8'h00, 15'h0, 0, 0, 15'h0044, 0, "R10 resume");
        // R11 prefix pair
        issue(XF_SEQ, 2'd1, 15'h0080, 8'h00, 8'h00, 8'h00, 8'h00, 15'h0, 1, 0, 15'h0081, 1, "R11 arm");
        issue(XF_SEQ, 2'd2, 15'h0081, 8'h00, 8'h00, 8'h00, 8'h00, 15'h0, 0, 1, 15'h0083, 1, "R11 prefix");
        issue(XF_PAGE, 2'd2, 15'h0083, 8'h21, 8'h00, 8'h00, 8'h00, 15'h0, 0, 0, 15'h0085, 0, "R11 pair end");
        issue(XF_PAGE, 2'd2, 15'h0085, 8'h21, 8'h00, 8'h00, 8'h00, 15'h0, 0, 0, 15'h0100, 0, "R11 after pair");
        // R12 hold
        idle(4);
        check("R12 hold pc", {1'b0, pc_next_o}, 16'h0100);
        check("R12 hold skip", {15'b0, skip_pend_o}, 16'h0);
        issue(XF_SEQ, 2'd1, 15'h0300, 8'h00, 8'h00, 8'h00, 8'h00, 15'h0, 1, 0, 15'h0301, 1, "R12 arm");
        idle(4);
        check("R12 hold armed pc", {1'b0, pc_next_o}, 16'h0301);
        check("R12 hold armed skip", {15'b0, skip_pend_o}, 16'h1);
        issue(XF_TRAP, 2'd1, 15'h0301, 8'h00, 8'h00, 8'h00, 8'h00, 15'h0, 0, 0, 15'h0302, 0, "R10 after idle");
        idle(3);
        check("scoreboard drained", 16'(sb.size()), 16'h0);

        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

endmodule